// File: doc/BRIEF.md
# Fully Associative Write-Back Cache

This block is a four-entry cache placed between a processor request port and a slower word-wide memory port. The processor issues a read or a write with a 6-bit byte address through a valid/ready handshake. The cache returns a response strobe with a 32-bit word. Each entry holds one word. The two low address bits select a byte inside that word, so they play no part in the lookup, and the upper four bits form the tag. There is no index field, so a lookup compares the tag against all four entries at once.

On a hit the response is produced from the stored word. On a miss the cache picks a destination entry. It takes the lowest-numbered empty entry if one exists. Otherwise it takes the least recently used entry, tracked by a 2-bit rank per entry. If the chosen entry holds modified data, that word is first written back to memory. The missing word is then read from memory and placed in the entry. A write merges its data into the entry (write-allocate) and marks the entry modified. Memory is updated only when a modified entry is evicted.

The memory port holds a request (valid, direction, word-aligned address, write data) until the memory raises `mem_ack`. For a read, the returned word is taken in the same cycle as `mem_ack`. While a miss is being serviced, the processor port is not ready.

Top module: `fa_wb_cache`

## Requirements
- R1: After reset `cpu_req_ready` is 1, `cpu_resp_valid` is 0 and `mem_req_valid` is 0; every entry is empty and all four ranks are distinct, so the first access to any address misses.
- R2: A read whose tag (address bits 5:2) matches a filled entry raises `cpu_resp_valid` in the cycle after acceptance, with that entry's word, and issues no memory request.
- R3: A read miss raises `mem_req_valid` with `mem_req_write`=0 and `mem_req_addr` = {tag, 2'b00}. In the cycle after `mem_ack` it raises `cpu_resp_valid` with the word that memory returned.
- R4: While any entry is empty, a miss fills an empty entry (the lowest-numbered one) and never writes back a filled entry.
- R5: With all entries filled, a miss replaces the entry used least recently, where both hits and fills count as uses. The ranks always form a permutation of 0..3.
- R6: A write hit replaces the entry's word and marks it modified without any memory request. The response carries the new word, and later reads return it.
- R7: Evicting a modified entry first issues a memory write (`mem_req_write`=1) of its word to {old tag, 2'b00}. The refill read is issued only in the cycle after that write's `mem_ack`. Evicting an unmodified entry issues no write.
- R8: A write miss reads the word from memory, stores the write data in its place, marks the entry modified, and responds with the write data in the cycle after the refill `mem_ack`.
- R9: From acceptance of a miss until its refill `mem_ack`, `cpu_req_ready` is 0. An outstanding memory request keeps its direction and address unchanged until `mem_ack`.
- R10: Address bits 1:0 are ignored: addresses that differ only there refer to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 6 | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_req_ready | output | 1 | Request accepted when valid and ready |
| cpu_resp_valid | output | 1 | One-cycle response strobe |
| cpu_resp_rdata | output | 32 | Word now held for the requested address |
| mem_req_valid | output | 1 | Memory request outstanding |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr | output | 6 | Word-aligned memory address |
| mem_req_wdata | output | 32 | Word being written back |
| mem_ack | input | 1 | Memory completes the outstanding request |
| mem_rdata | input | 32 | Refill word, valid with `mem_ack` on a read |

## Verification
A hit is due exactly one cycle after the accepting edge, with no memory activity. A miss presents its first memory request one cycle after acceptance. A write-back is followed by the refill read one cycle after its acknowledge, and the response follows one cycle after the refill acknowledge. The bench drives and samples on falling edges and steps through these cycles one at a time against a behavioural model of the entries and their use order. Memory acknowledges are delayed by a different number of cycles per access, so that the stall, the held request and the write-before-read order are each checked over several waiting cycles.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } fsm_e;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int SLOTS = 4,
    parameter int TAG_W = 4,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0]            vld_i,
    input  logic [SLOTS-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]            look_i,
    output logic                        hit_o,
    output logic [IDX_W-1:0]            idx_o
);
    logic [SLOTS-1:0] eq;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign eq[g] = vld_i[g] && (tag_i[g] == look_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/fa_victim_pick.sv
module fa_victim_pick #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0]            vld_i,
    input  logic [SLOTS-1:0][IDX_W-1:0] rank_i,
    output logic [IDX_W-1:0]            victim_o
);
    logic [IDX_W-1:0] oldest;
    logic [IDX_W-1:0] empty_idx;

    always_comb begin
        oldest = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rank_i[i] == IDX_W'(SLOTS - 1)) oldest = IDX_W'(i);
        end
        empty_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!vld_i[i]) empty_idx = IDX_W'(i);
        end
    end

    assign victim_o = (&vld_i) ? oldest : empty_idx;
endmodule

// File: rtl/fa_lru_touch.sv
module fa_lru_touch #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 2
) (
    input  logic [SLOTS-1:0][IDX_W-1:0] rank_i,
    input  logic [IDX_W-1:0]            touch_i,
    output logic [SLOTS-1:0][IDX_W-1:0] rank_o
);
    logic [IDX_W-1:0] pivot;
    assign pivot = rank_i[touch_i];

    for (genvar g = 0; g < SLOTS; g++) begin : g_rank
        always_comb begin
            if (touch_i == IDX_W'(g))   rank_o[g] = '0;
            else if (rank_i[g] < pivot) rank_o[g] = rank_i[g] + 1'b1;
            else                        rank_o[g] = rank_i[g];
        end
    end
endmodule

// File: rtl/fa_wb_cache.sv
module fa_wb_cache
    import fa_cache_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        fsm_e                              st;
        logic [SLOTS-1:0]                  vld;
        logic [SLOTS-1:0]                  dty;
        logic [SLOTS-1:0][TAG_W-1:0]       tag;
        logic [SLOTS-1:0][DATA_W-1:0]      dat;
        logic [SLOTS-1:0][IDX_W-1:0]       rank;
        logic                              rq_wr;
        logic [TAG_W-1:0]                  rq_tag;
        logic [DATA_W-1:0]                 rq_wdata;
        logic [IDX_W-1:0]                  vic;
        logic                              rsp;
        logic [DATA_W-1:0]                 rsp_data;
    } state_t;

    state_t q, d;

    logic [TAG_W-1:0]             req_tag;
    logic                         hit;
    logic [IDX_W-1:0]             hit_idx;
    logic [IDX_W-1:0]             victim;
    logic [IDX_W-1:0]             touch_idx;
    logic [SLOTS-1:0][IDX_W-1:0]  rank_touched;
    logic [DATA_W-1:0]            fill_word;
    logic                         unused_offset;

    assign req_tag       = cpu_req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^cpu_req_addr[OFF_W-1:0];
    assign touch_idx     = (q.st == ST_IDLE) ? hit_idx : q.vic;

    fa_tag_match #(.SLOTS(SLOTS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .vld_i  (q.vld),
        .tag_i  (q.tag),
        .look_i (req_tag),
        .hit_o  (hit),
        .idx_o  (hit_idx)
    );

    fa_victim_pick #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_victim (
        .vld_i    (q.vld),
        .rank_i   (q.rank),
        .victim_o (victim)
    );

    fa_lru_touch #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_lru (
        .rank_i  (q.rank),
        .touch_i (touch_idx),
        .rank_o  (rank_touched)
    );

    always_comb begin
        d         = q;
        d.rsp     = 1'b0;
        fill_word = q.rq_wr ? q.rq_wdata : mem_rdata;
        case (q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    if (hit) begin
                        if (cpu_req_write) begin
                            d.dat[hit_idx] = cpu_req_wdata;
                            d.dty[hit_idx] = 1'b1;
                        end
                        d.rsp      = 1'b1;
                        d.rsp_data = cpu_req_write ? cpu_req_wdata : q.dat[hit_idx];
                        d.rank     = rank_touched;
                    end else begin
                        d.rq_wr    = cpu_req_write;
                        d.rq_tag   = req_tag;
                        d.rq_wdata = cpu_req_wdata;
                        d.vic      = victim;
                        d.st       = (q.vld[victim] && q.dty[victim]) ? ST_EVICT : ST_FILL;
                    end
                end
            end
            ST_EVICT: begin
                if (mem_ack) begin
                    d.dty[q.vic] = 1'b0;
                    d.st         = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    d.dat[q.vic] = fill_word;
                    d.tag[q.vic] = q.rq_tag;
                    d.vld[q.vic] = 1'b1;
                    d.dty[q.vic] = q.rq_wr;
                    d.rank       = rank_touched;
                    d.rsp        = 1'b1;
                    d.rsp_data   = fill_word;
                    d.st         = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            for (int i = 0; i < SLOTS; i++) q.rank[i] <= IDX_W'(i);
        end else begin
            q <= d;
        end
    end

    assign cpu_req_ready  = (q.st == ST_IDLE);
    assign cpu_resp_valid = q.rsp;
    assign cpu_resp_rdata = q.rsp_data;
    assign mem_req_valid  = (q.st != ST_IDLE);
    assign mem_req_write  = (q.st == ST_EVICT);
    assign mem_req_addr   = {(q.st == ST_EVICT) ? q.tag[q.vic] : q.rq_tag, {OFF_W{1'b0}}};
    assign mem_req_wdata  = q.dat[q.vic];

    // Assertions
    logic [SLOTS-1:0][SLOTS-1:0] rank_owner;
    always_comb begin
        for (int r = 0; r < SLOTS; r++)
            for (int s = 0; s < SLOTS; s++)
                rank_owner[r][s] = (q.rank[s] == IDX_W'(r));
    end

    for (genvar r = 0; r < SLOTS; r++) begin : g_perm
        a_r5_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rank_owner[r]) == 1);
    end

    a_r2_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && hit |=> cpu_resp_valid && !mem_req_valid);

    a_r4_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && !hit && !(&q.vld) |=> mem_req_valid && !mem_req_write);

    a_r7_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && mem_ack |=> mem_req_valid && !mem_req_write);

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_write)
                                      && $stable(mem_req_addr) && !cpu_req_ready);

    a_r3_resp_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_write && mem_ack |=> cpu_resp_valid && cpu_req_ready);
endmodule

// File: tb/fa_wb_cache_bench.sv
`timescale 1ns/1ps
module fa_wb_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_write = 1'b0;
    logic [5:0]  cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready;
    logic        cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [5:0]  mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    fa_wb_cache u_fa_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural model: entry contents plus a use-order queue (front = newest)
    bit [3:0]  m_tag [4];
    bit [31:0] m_dat [4];
    bit        m_v   [4];
    bit        m_d   [4];
    int        order [$];
    bit [31:0] bmem  [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic touch(input int s);
        foreach (order[k]) if (order[k] == s) begin order.delete(k); break; end
        order.push_front(s);
    endtask

    task automatic access(input bit wr, input logic [5:0] addr,
                          input logic [31:0] wd, input int dly);
        bit [3:0] t = addr[5:2];
        int hs = -1;
        int vs = -1;
        bit [31:0] expw;
        for (int s = 0; s < 4; s++) if (m_v[s] && m_tag[s] == t) hs = s;
        cpu_req_valid = 1'b1; cpu_req_write = wr;
        cpu_req_addr = addr;  cpu_req_wdata = wd;
        chk(cpu_req_ready == 1'b1, "R9", "ready when idle", 32'(cpu_req_ready), 1);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        if (hs >= 0) begin
            expw = wr ? wd : m_dat[hs];
            chk(cpu_resp_valid == 1'b1, wr ? "R6" : "R2", "hit response strobe", 32'(cpu_resp_valid), 1);
            chk(cpu_resp_rdata == expw, (addr[1:0] != 0) ? "R10" : (wr ? "R6" : "R2"),
                "hit data", cpu_resp_rdata, expw);
            chk(mem_req_valid == 1'b0, wr ? "R6" : "R2", "no memory on hit", 32'(mem_req_valid), 0);
            if (wr) begin m_dat[hs] = wd; m_d[hs] = 1'b1; end
            touch(hs);
            return;
        end
        for (int s = 3; s >= 0; s--) if (!m_v[s]) vs = s;
        if (vs < 0) vs = order[$];
        if (m_v[vs] && m_d[vs]) begin
            chk(mem_req_valid && mem_req_write, "R7", "write-back issued first",
                {mem_req_valid, mem_req_write}, 2'b11);
            chk(mem_req_addr == {m_tag[vs], 2'b00}, "R5", "evicted entry address",
                32'(mem_req_addr), 32'({m_tag[vs], 2'b00}));
            chk(mem_req_wdata == m_dat[vs], "R7", "write-back data", mem_req_wdata, m_dat[vs]);
            for (int c = 0; c < dly; c++) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_write && !cpu_req_ready, "R9",
                    "write-back held, port stalled",
                    {mem_req_valid, mem_req_write, cpu_req_ready}, 3'b110);
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            bmem[m_tag[vs]] = m_dat[vs];
        end
        chk(mem_req_valid && !mem_req_write, m_v[vs] ? "R7" : "R4", "refill read issued",
            {mem_req_valid, mem_req_write}, 2'b10);
        chk(mem_req_addr == {t, 2'b00}, "R3", "refill address", 32'(mem_req_addr), 32'({t, 2'b00}));
        chk(cpu_req_ready == 1'b0, "R9", "stalled during miss", 32'(cpu_req_ready), 0);
        for (int c = 0; c < dly; c++) begin
            @(negedge clk);
            chk(mem_req_valid && !mem_req_write && mem_req_addr == {t, 2'b00} && !cpu_req_ready,
                "R9", "refill held", 32'(mem_req_addr), 32'({t, 2'b00}));
        end
        mem_ack = 1'b1;
        mem_rdata = bmem[t];
        @(negedge clk);
        mem_ack = 1'b0;
        mem_rdata = '0;
        expw = wr ? wd : bmem[t];
        chk(cpu_resp_valid == 1'b1, wr ? "R8" : "R3", "miss response strobe", 32'(cpu_resp_valid), 1);
        chk(cpu_resp_rdata == expw, wr ? "R8" : "R3", "miss response data", cpu_resp_rdata, expw);
        m_v[vs] = 1'b1; m_d[vs] = wr; m_tag[vs] = t; m_dat[vs] = expw;
        touch(vs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] seed = 32'h1234_5678;
        for (int i = 0; i < 16; i++) bmem[i] = 32'hA000_0000 + 32'(i) * 32'h0101_1111;
        for (int s = 0; s < 4; s++) begin m_v[s] = 0; m_d[s] = 0; m_tag[s] = 0; m_dat[s] = 0; end
        order = {0, 1, 2, 3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cpu_req_ready == 1'b1, "R1", "ready after reset", 32'(cpu_req_ready), 1);
        chk(cpu_resp_valid == 1'b0, "R1", "no response after reset", 32'(cpu_resp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1", "no memory request after reset", 32'(mem_req_valid), 0);
        access(0, 6'h00, 0, 2);            // R3 read miss
        access(0, 6'h03, 0, 0);            // R10 offset ignored, R2 hit
        access(1, 6'h04, 32'h1234_5678, 1); // R8 write-allocate
        access(1, 6'h08, 32'hCAFE_0008, 0); // R4 fills empty entries
        access(1, 6'h0C, 32'hCAFE_000C, 3);
        access(0, 6'h05, 0, 0);            // R6 read back written word
        access(1, 6'h06, 32'hBEEF_0006, 0); // R6 write hit
        access(0, 6'h00, 0, 0);
        access(0, 6'h10, 0, 2);            // R5/R7 evicts 0x08, dirty
        access(0, 6'h08, 0, 1);            // R7 reload after write-back
        access(0, 6'h14, 0, 0);            // evicts 0x04 holding write-hit data
        access(0, 6'h18, 0, 1);            // R7 clean eviction: no write
        access(0, 6'h04, 0, 0);            // R7 memory got the written-back word
        for (int n = 0; n < 80; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            access(seed[20], seed[13:8], seed ^ 32'h5A5A_0000, int'(seed[25:24]));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule